// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines from peripherals, latches each new request as pending, and chooses among the pending lines that are not masked. Line 0 has the highest priority. When at least one eligible line exists, it raises a single request output toward the processor. The processor answers with a one-cycle acknowledge. During that cycle the block places a vector byte on its data output. The vector is a programmable base with the winning line's index in the low bits, so the processor can use it to find the matching handler routine.

Each line has an in-service flag, set on acknowledge, that records which handlers are running. While a line is in service, requests of the same or lower priority are held back. A request of higher priority can still interrupt, so handlers nest. An end-of-interrupt command clears the in-service flag of the highest-priority line that is in service. A mask register stops lines from taking part in arbitration, but their pending state is kept.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `intr`, `vec_oe` and `vec_data` are 0, the mask is all zero (every line enabled), the vector base is 0 and no line is pending or in service.
- R2: In the default edge mode, a low-to-high change on `irq_req[i]` sampled at a clock edge makes line i pending, and `intr` reads 1 from that edge on. A request held high is latched only once.
- R3: When several eligible lines are pending, the lowest index wins.
- R4: While `inta` is 1, `vec_oe` is 1 and `vec_data` equals {base[7:3], index[2:0]} of the winning line. The low three bits written through `base_din` are ignored.
- R5: While `inta` is 0, `vec_oe` is 0 and `vec_data` is 0.
- R6: An acknowledge clears the winner's pending flag and sets its in-service flag. A line is never served twice for one request edge, even if its input stays high.
- R7: While line j is in service, lines with index j or greater do not raise `intr`, and a pending line with index below j does raise it.
- R8: An `eoi` pulse clears only the in-service flag with the lowest index. Requests that this flag had been blocking then raise `intr`.
- R9: A line whose mask bit is 1 is skipped in arbitration but keeps its pending flag. Clearing the mask bit makes it eligible again.
- R10: An acknowledge while `intr` is 0 returns the vector {base[7:3], 3'b111} and changes no pending or in-service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Interrupt request lines, index 0 highest priority |
| mask_wr | input | 1 | Load the mask register from `mask_din` |
| mask_din | input | 8 | New mask value, 1 disables a line |
| base_wr | input | 1 | Load the vector base from `base_din` |
| base_din | input | 8 | New vector base; bits 2:0 ignored |
| inta | input | 1 | One-cycle acknowledge from the processor |
| eoi | input | 1 | End-of-interrupt command pulse |
| intr | output | 1 | Interrupt request toward the processor |
| vec_data | output | 8 | Vector byte, nonzero only in the acknowledge cycle |
| vec_oe | output | 1 | Data output enable, high during acknowledge |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `inta` and `eoi` are single-cycle pulses. An acknowledge that lasts longer would be counted as several acknowledges. The bench changes every input just after a falling edge and raises `inta` and `eoi` for exactly one cycle each. It always issues an end-of-interrupt for each acknowledged line before the next scenario starts, so in-service nesting never depends on leftover state.

// File: rtl/vic_pkg.sv
package vic_pkg;

   // How a request line becomes pending.
   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_e;

endpackage

// File: rtl/vic_lowest_pick.sv
// Finds the lowest set bit of a vector. With no bit set, the index is all ones.
module vic_lowest_pick #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      idx_o = '1;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |vec_i;

endmodule

// File: rtl/vic_req_capture.sv
// Turns raw request lines into pending flags; the trigger variant is chosen by parameter.
module vic_req_capture
   import vic_pkg::*;
#(
   parameter int    N    = 8,
   parameter trig_e TRIG = TRIG_EDGE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   logic [N-1:0] set_w;
   logic [N-1:0] pend_q;

   generate
      if (TRIG == TRIG_EDGE) begin : g_edge
         logic [N-1:0] prev_q;

         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= req_i;
         end

         assign set_w = req_i & ~prev_q;

         // A pending flag only appears after a sampled rising edge of its line.
         assert_pend_from_edge_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            ((pend_q & ~$past(pend_q)) & ~($past(req_i) & ~$past(prev_q))) == '0);
      end else begin : g_level
         assign set_w = req_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_i) | set_w;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/vic_service_track.sv
// In-service flags: set on acknowledge, lowest one cleared on end-of-interrupt.
module vic_service_track #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_i,
   input  logic [IDX_W-1:0] ack_idx_i,
   input  logic             eoi_i,
   output logic [N-1:0]     allow_o,
   output logic             top_any_o,
   output logic [IDX_W-1:0] top_idx_o
);

   logic [N-1:0] isr_q;
   logic [N-1:0] eoi_clr;
   logic [N-1:0] ack_set;

   vic_lowest_pick #(.N(N), .IDX_W(IDX_W)) u_top (
      .vec_i (isr_q),
      .any_o (top_any_o),
      .idx_o (top_idx_o)
   );

   always_comb begin
      for (int i = 0; i < N; i++) begin
         eoi_clr[i] = eoi_i && top_any_o && (top_idx_o == IDX_W'(i));
         ack_set[i] = ack_i && (ack_idx_i == IDX_W'(i));
      end
   end

   // A line may compete only while no line at or above its priority is in service.
   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < N; i++) begin
         seen       = seen | isr_q[i];
         allow_o[i] = ~seen;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~eoi_clr) | ack_set;
   end

   assert_ack_marks_service_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> isr_q[$past(ack_idx_i)]);

   assert_eoi_drops_one_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && (isr_q != '0) && !ack_i) |=>
         ($countones(isr_q) == $countones($past(isr_q)) - 1));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int    NUM_LINES = 8,
   parameter int    VEC_W     = 8,
   parameter trig_e TRIG      = TRIG_EDGE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req,
   input  logic                 mask_wr,
   input  logic [NUM_LINES-1:0] mask_din,
   input  logic                 base_wr,
   input  logic [VEC_W-1:0]     base_din,
   input  logic                 inta,
   input  logic                 eoi,
   output logic                 intr,
   output logic [VEC_W-1:0]     vec_data,
   output logic                 vec_oe
);

   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int BASE_W = VEC_W - IDX_W;

   generate
      if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
         $error("NUM_LINES must be a power of two, at least 2");
      end
      if (VEC_W <= IDX_W) begin : g_bad_width
         $error("VEC_W must exceed the index width");
      end
   endgenerate

   logic [NUM_LINES-1:0] mask_q;
   logic [BASE_W-1:0]    base_hi_q;
   logic [NUM_LINES-1:0] pend_w;
   logic [NUM_LINES-1:0] allow_w;
   logic [NUM_LINES-1:0] elig_w;
   logic [NUM_LINES-1:0] ack_oh;
   logic                 any_w;
   logic [IDX_W-1:0]     sel_idx;
   logic                 ack_w;
   logic                 isr_any;
   logic [IDX_W-1:0]     isr_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '0;
         base_hi_q <= '0;
      end else begin
         if (mask_wr) mask_q    <= mask_din;
         if (base_wr) base_hi_q <= base_din[VEC_W-1:IDX_W];
      end
   end

   vic_req_capture #(.N(NUM_LINES), .TRIG(TRIG)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (irq_req),
      .clr_i  (ack_oh),
      .pend_o (pend_w)
   );

   vic_service_track #(.N(NUM_LINES), .IDX_W(IDX_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_i     (ack_w),
      .ack_idx_i (sel_idx),
      .eoi_i     (eoi),
      .allow_o   (allow_w),
      .top_any_o (isr_any),
      .top_idx_o (isr_idx)
   );

   assign elig_w = pend_w & ~mask_q & allow_w;

   vic_lowest_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
      .vec_i (elig_w),
      .any_o (any_w),
      .idx_o (sel_idx)
   );

   assign intr  = any_w;
   assign ack_w = inta & any_w;

   always_comb begin
      for (int i = 0; i < NUM_LINES; i++) begin
         ack_oh[i] = ack_w && (sel_idx == IDX_W'(i));
      end
   end

   assign vec_oe   = inta;
   assign vec_data = inta ? {base_hi_q, sel_idx} : '0;

   // The winner must rank above every line in service.
   assert_pick_above_service_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (intr && isr_any) |-> (sel_idx < isr_idx));

   // A masked line is never the one offered to the processor.
   assert_masked_skipped_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> !mask_q[sel_idx]);

   // A spurious acknowledge leaves the pending flags untouched.
   assert_spurious_keeps_state_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !intr) |=> (pend_w & ~$past(pend_w)) == (pend_w & ~$past(pend_w) & $past(irq_req)));

endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq_req;
   logic       mask_wr;
   logic [7:0] mask_din;
   logic       base_wr;
   logic [7:0] base_din;
   logic       inta;
   logic       eoi;
   logic       intr;
   logic [7:0] vec_data;
   logic       vec_oe;

   int n_checks = 0;
   int n_fail   = 0;

   localparam logic [7:0] BASE_HI = 8'hA0;

   always #10 clk = ~clk;

   vec_irq_ctrl u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_req  (irq_req),
      .mask_wr  (mask_wr),
      .mask_din (mask_din),
      .base_wr  (base_wr),
      .base_din (base_din),
      .inta     (inta),
      .eoi      (eoi),
      .intr     (intr),
      .vec_data (vec_data),
      .vec_oe   (vec_oe)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic expect_intr(input logic exp, input string tag);
      check(intr === exp, tag, int'(intr), int'(exp));
   endtask

   // One-cycle acknowledge; checks the vector seen while inta is high.
   task automatic ack_expect(input logic [7:0] exp_vec, input string tag);
      @(negedge clk);
      inta = 1'b1;
      #1;
      check(vec_oe === 1'b1, {tag, " R4 oe"}, int'(vec_oe), 1);
      check(vec_data === exp_vec, {tag, " R4 vector"}, int'(vec_data), int'(exp_vec));
      @(negedge clk);
      inta = 1'b0;
      #1;
      check(vec_oe === 1'b0 && vec_data === 8'h00, {tag, " R5 bus released"},
            int'({vec_oe, vec_data}), 0);
   endtask

   task automatic pulse_eoi();
      @(negedge clk);
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
      #1;
   endtask

   task automatic raise(input int line);
      @(negedge clk);
      irq_req[line] = 1'b1;
      tick();
   endtask

   task automatic write_mask(input logic [7:0] m);
      @(negedge clk);
      mask_wr  = 1'b1;
      mask_din = m;
      @(negedge clk);
      mask_wr = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      check(intr === 1'b0, "R1 intr after reset", int'(intr), 0);
      check(vec_oe === 1'b0, "R1 vec_oe after reset", int'(vec_oe), 0);
      check(vec_data === 8'h00, "R1 vec_data after reset", int'(vec_data), 0);
   endtask

   task automatic t_spurious();
      // base still 0 here: spurious vector is 0x07
      ack_expect(8'h07, "R10 spurious with reset base");
      expect_intr(1'b0, "R10 no request after spurious ack");
   endtask

   task automatic t_single();
      @(negedge clk);
      base_wr  = 1'b1;
      base_din = 8'hA5;
      @(negedge clk);
      base_wr = 1'b0;
      raise(3);
      expect_intr(1'b1, "R2 edge on line 3 raises intr");
      ack_expect(BASE_HI | 8'h03, "R4 line 3");
      expect_intr(1'b0, "R6 held line 3 not re-latched");
      pulse_eoi();
      tick();
      expect_intr(1'b0, "R6 line 3 not served twice after eoi");
      @(negedge clk);
      irq_req[3] = 1'b0;
      tick();
   endtask

   task automatic t_spurious_no_service();
      ack_expect(BASE_HI | 8'h07, "R10 spurious vector");
      raise(7);
      expect_intr(1'b1, "R10 line 7 not left in service");
      ack_expect(BASE_HI | 8'h07, "R10 real line 7");
      pulse_eoi();
      @(negedge clk);
      irq_req[7] = 1'b0;
      tick();
   endtask

   task automatic t_priority();
      @(negedge clk);
      irq_req[5] = 1'b1;
      irq_req[2] = 1'b1;
      tick();
      expect_intr(1'b1, "R3 two lines pending");
      ack_expect(BASE_HI | 8'h02, "R3 line 2 beats line 5");
      expect_intr(1'b0, "R7 line 5 blocked by line 2 in service");
      pulse_eoi();
      expect_intr(1'b1, "R8 line 5 released by eoi");
      ack_expect(BASE_HI | 8'h05, "R3 line 5 after eoi");
      pulse_eoi();
      @(negedge clk);
      irq_req = '0;
      tick();
      expect_intr(1'b0, "R6 nothing left pending");
   endtask

   task automatic t_nesting();
      raise(4);
      ack_expect(BASE_HI | 8'h04, "R4 line 4");
      raise(6);
      expect_intr(1'b0, "R7 lower line 6 blocked");
      raise(4 - 3);
      expect_intr(1'b1, "R7 higher line 1 nests");
      ack_expect(BASE_HI | 8'h01, "R7 line 1 nested vector");
      pulse_eoi();
      expect_intr(1'b0, "R8 eoi cleared line 1 only, line 4 still blocks");
      pulse_eoi();
      expect_intr(1'b1, "R8 line 6 released");
      ack_expect(BASE_HI | 8'h06, "R8 line 6 vector");
      pulse_eoi();
      @(negedge clk);
      irq_req = '0;
      tick();
   endtask

   task automatic t_mask();
      write_mask(8'h01);
      raise(0);
      expect_intr(1'b0, "R9 masked line 0 ignored");
      raise(7);
      expect_intr(1'b1, "R9 unmasked line 7 requests");
      ack_expect(BASE_HI | 8'h07, "R9 line 7 wins over masked line 0");
      pulse_eoi();
      expect_intr(1'b0, "R9 line 0 still masked");
      write_mask(8'h00);
      expect_intr(1'b1, "R9 line 0 pending kept through mask");
      ack_expect(BASE_HI | 8'h00, "R9 line 0 after unmask");
      pulse_eoi();
      @(negedge clk);
      irq_req = '0;
      tick();
      expect_intr(1'b0, "R6 idle after mask scenario");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      irq_req  = '0;
      mask_wr  = 1'b0;
      mask_din = '0;
      base_wr  = 1'b0;
      base_din = '0;
      inta     = 1'b0;
      eoi      = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_spurious();
      t_single();
      t_spurious_no_service();
      t_priority();
      t_nesting();
      t_mask();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule